// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block holds one exclusive reservation for a processor core so that software can build atomic read-modify-write sequences. A load-exclusive request computes its effective address, issues the read, and arms the monitor with that address and the access size. A later store-exclusive request is checked against the armed reservation. The write is allowed only when the monitor is still armed, the address and the size both match, and nothing has disturbed the reservation. The core receives a one-bit status for its destination register: 0 means the store went out, 1 means it was suppressed.

The monitor also watches a snoop port that carries writes from other bus masters. A write that lands in the reserved 4-byte granule drops the reservation. A clear input, driven on exception entry or by an explicit clear request, returns the monitor to the open state, and so does reset. Requests arrive one per cycle. The read enable, write enable and status are combinational on the request, and the reservation state updates at the next clock edge.

Top module: `excl_monitor`

## Requirements
- R1: The size code is 2 bits: 0 is byte, 1 is halfword, 2 is word. Code 3 is reserved. A load with code 3 does not arm the monitor, and a store with code 3 always fails with status 1.
- R2: For a word request, `eff_addr` equals `req_base + 4*req_imm`, where `req_imm` is an unsigned word count from 0 to 255, giving a byte offset of 0 to 1020. For byte and halfword requests, `eff_addr` equals `req_base` and `req_imm` is ignored.
- R3: A load-exclusive (`req_valid`=1, `req_store`=0) raises `mem_rd_en` in the same cycle. From the next cycle on, `armed` is 1 with that effective address and size recorded.
- R4: A store-exclusive is granted only when the monitor is armed and both its effective address and its size equal the recorded ones. When granted, `mem_wr_en`=1 and `st_status`=0 in the same cycle, with `st_valid`=1.
- R5: A store-exclusive that is not granted gives `mem_wr_en`=0 and `st_status`=1, with `st_valid`=1. This covers an unarmed monitor, an address mismatch and a size mismatch.
- R6: Every store-exclusive leaves `armed`=0 in the next cycle, whether it was granted or not.
- R7: A snooped write (`snp_valid`=1) whose address lies in the same 4-byte-aligned granule as the reservation clears `armed` at the next edge. A store-exclusive in the same cycle as such a snoop fails.
- R8: `excl_clr`=1 leaves `armed`=0 in the next cycle. It takes priority over a load-exclusive in the same cycle, and a store-exclusive in the same cycle as it fails. Reset also leaves `armed`=0.
- R9: A new load-exclusive replaces any earlier reservation. A store to the older address then fails, and a store to the newer address succeeds.
- R10: A snooped write to a different granule leaves the reservation armed, and a following matching store still succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exclusive request present this cycle |
| req_store | input | 1 | 1 = store-exclusive, 0 = load-exclusive |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 reserved) |
| req_base | input | ADDR_W | Base register value |
| req_imm | input | OFFS_W | Word-count offset, used by word requests only |
| excl_clr | input | 1 | Clear-exclusive request |
| snp_valid | input | 1 | Write by another master observed |
| snp_addr | input | ADDR_W | Address of the observed write |
| eff_addr | output | ADDR_W | Effective address of the request |
| mem_rd_en | output | 1 | Issue the exclusive read |
| mem_wr_en | output | 1 | Store granted, issue the write |
| st_valid | output | 1 | Status for a store-exclusive is present |
| st_status | output | 1 | 0 = store performed, 1 = store suppressed |
| armed | output | 1 | Reservation currently held |

## Verification
The bench builds the monitor with its default parameters: a 32-bit address, an 8-bit word-count offset and a 4-byte granule. The 8-bit offset lets the largest immediate of 255 words, a 1020-byte offset, be driven directly. The 4-byte granule lets a snoop inside the reserved word but at a different byte be told apart from a snoop to the next word. With these values the directed scenarios reach every way a store can fail: the monitor is unarmed, the address or size does not match, a snoop or a clear arrives in the same cycle, or the reservation was replaced. They also cover the reserved size code and a reset in the middle of a sequence.

// File: rtl/excl_pkg.sv
package excl_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xsize_e;

   function automatic logic size_ok(input logic [1:0] s);
      return s != SZ_RSVD;
   endfunction
endpackage

// File: rtl/excl_addr_gen.sv
module excl_addr_gen
   import excl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFFS_W-1:0] imm,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] eff
);
   localparam int SCL_W = OFFS_W + 2;

   logic [ADDR_W-1:0] scaled;

   generate
      if (SCL_W == ADDR_W) begin : g_full
         assign scaled = {imm, 2'b00};
      end else begin : g_ext
         assign scaled = {{(ADDR_W-SCL_W){1'b0}}, imm, 2'b00};
      end
   endgenerate

   always_comb begin
      if (size == SZ_WORD) eff = base + scaled;
      else                 eff = base;
   end
endmodule

// File: rtl/excl_snoop_cmp.sv
module excl_snoop_cmp #(
   parameter int ADDR_W  = 32,
   parameter int GRAN_LG = 2
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   output logic              same
);
   generate
      if (GRAN_LG == 0) begin : g_exact
         assign same = (a == b);
      end else begin : g_gran
         assign same = (a[ADDR_W-1:GRAN_LG] == b[ADDR_W-1:GRAN_LG]);
      end
   endgenerate
endmodule

// File: rtl/excl_resv.sv
module excl_resv #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              arm,
   input  logic              drop,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic [1:0]        arm_size,
   output logic              armed,
   output logic [ADDR_W-1:0] res_addr,
   output logic [1:0]        res_size
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         res_addr <= '0;
         res_size <= 2'd0;
      end else if (clr) begin
         armed <= 1'b0;
      end else if (arm) begin
         armed    <= 1'b1;
         res_addr <= arm_addr;
         res_size <= arm_size;
      end else if (drop) begin
         armed <= 1'b0;
      end
   end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
   import excl_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFFS_W  = 8,
   parameter int GRAN_LG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [OFFS_W-1:0] req_imm,
   input  logic              excl_clr,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic              st_valid,
   output logic              st_status,
   output logic              armed
);
   generate
      if (ADDR_W < 8)               begin : g_bad_aw  $error("ADDR_W too small");        end
      if (OFFS_W + 2 > ADDR_W)      begin : g_bad_ow  $error("OFFS_W too wide");         end
      if (GRAN_LG >= ADDR_W)        begin : g_bad_gr  $error("GRAN_LG out of range");    end
   endgenerate

   logic [ADDR_W-1:0] res_addr;
   logic [1:0]        res_size;
   logic              snp_same;
   logic              snp_hit;
   logic              is_load;
   logic              is_store;
   logic              match;

   excl_addr_gen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_agen (
      .base (req_base),
      .imm  (req_imm),
      .size (req_size),
      .eff  (eff_addr)
   );

   excl_snoop_cmp #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) u_snp (
      .a    (snp_addr),
      .b    (res_addr),
      .same (snp_same)
   );

   assign is_load  = req_valid && !req_store;
   assign is_store = req_valid &&  req_store;
   assign snp_hit  = snp_valid && armed && snp_same;
   assign match    = armed && size_ok(req_size) &&
                     (eff_addr == res_addr) && (req_size == res_size);

   assign mem_rd_en = is_load;
   assign mem_wr_en = is_store && match && !snp_hit && !excl_clr;
   assign st_valid  = is_store;
   assign st_status = is_store && !mem_wr_en;

   excl_resv #(.ADDR_W(ADDR_W)) u_resv (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (excl_clr),
      .arm      (is_load && size_ok(req_size)),
      .drop     (is_store || snp_hit),
      .arm_addr (eff_addr),
      .arm_size (req_size),
      .armed    (armed),
      .res_addr (res_addr),
      .res_size (res_size)
   );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
   parameter int ADDR_W  = 32,
   parameter int GRAN_LG = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_store,
   input logic [1:0]        req_size,
   input logic              excl_clr,
   input logic              snp_valid,
   input logic [ADDR_W-1:0] snp_addr,
   input logic [ADDR_W-1:0] res_addr,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic              st_valid,
   input logic              st_status,
   input logic              armed
);
   logic snp_in_gran;
   assign snp_in_gran = ((snp_addr >> GRAN_LG) == (res_addr >> GRAN_LG));

   AST_RESET_OPEN: assert property (@(posedge clk)
      !rst_n |=> !armed);                                                       // R8
   AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && req_size != 2'd3 && !excl_clr) |=> armed);    // R3
   AST_RSVD_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && req_valid && req_size == 2'd3) |=> !armed);                    // R1
   AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store) |=> !armed);                                     // R6
   AST_CLR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      excl_clr |=> !armed);                                                     // R8
   AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && armed && snp_in_gran && !(req_valid && !req_store))
      |=> !armed);                                                              // R7
   AST_GRANT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (armed && st_valid && !st_status));                         // R4
   AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_status) |-> !mem_wr_en);                                  // R5
   AST_RD_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !st_valid);                                                 // R3
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_store (req_store),
   .req_size  (req_size),
   .excl_clr  (excl_clr),
   .snp_valid (snp_valid),
   .snp_addr  (snp_addr),
   .res_addr  (res_addr),
   .mem_rd_en (mem_rd_en),
   .mem_wr_en (mem_wr_en),
   .st_valid  (st_valid),
   .st_status (st_status),
   .armed     (armed)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
   localparam int AW = 32;
   localparam int OW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_store = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_base = '0;
   logic [OW-1:0] req_imm = '0;
   logic          excl_clr = 1'b0, snp_valid = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic [AW-1:0] eff_addr;
   logic          mem_rd_en, mem_wr_en, st_valid, st_status, armed;

   int n_chk = 0, n_bad = 0;
   logic [AW-1:0] c_eff;
   logic          c_rd, c_wr, c_sv, c_st;

   always #4 clk = ~clk;

   excl_monitor #(.ADDR_W(AW), .OFFS_W(OW), .GRAN_LG(2)) u0 (.*);

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, capture combinational outputs, step past posedge.
   task automatic cyc(input logic v, input logic st, input logic [1:0] sz,
                      input logic [AW-1:0] base, input logic [OW-1:0] imm,
                      input logic sv, input logic [AW-1:0] sa, input logic clr);
      @(negedge clk);
      req_valid = v; req_store = st; req_size = sz; req_base = base; req_imm = imm;
      snp_valid = sv; snp_addr = sa; excl_clr = clr;
      #2;
      c_eff = eff_addr; c_rd = mem_rd_en; c_wr = mem_wr_en; c_sv = st_valid; c_st = st_status;
      @(posedge clk); #1;
      req_valid = 0; snp_valid = 0; excl_clr = 0;
   endtask

   task automatic ld(input logic [1:0] sz, input logic [AW-1:0] b, input logic [OW-1:0] i);
      cyc(1, 0, sz, b, i, 0, '0, 0);
   endtask
   task automatic sto(input logic [1:0] sz, input logic [AW-1:0] b, input logic [OW-1:0] i);
      cyc(1, 1, sz, b, i, 0, '0, 0);
   endtask

   task automatic t_reset;
      chk("R8 reset armed", armed, 0);
      chk("R8 reset st_valid", st_valid, 0);
   endtask

   task automatic t_word_ok;
      ld(2, 32'h1000, 8'd3);
      chk("R2 word eff", c_eff, 32'h100C);
      chk("R3 rd_en", c_rd, 1);
      chk("R3 armed", armed, 1);
      sto(2, 32'h1000, 8'd3);
      chk("R4 wr_en", c_wr, 1);
      chk("R4 status", c_st, 0);
      chk("R4 st_valid", c_sv, 1);
      chk("R6 cleared after ok", armed, 0);
   endtask

   task automatic t_unarmed;
      sto(2, 32'h1000, 8'd0);
      chk("R5 unarmed wr", c_wr, 0);
      chk("R5 unarmed status", c_st, 1);
   endtask

   task automatic t_size_mismatch;
      ld(1, 32'h2002, 8'd0);
      sto(0, 32'h2002, 8'd0);
      chk("R5 size mismatch wr", c_wr, 0);
      chk("R5 size mismatch status", c_st, 1);
   endtask

   task automatic t_addr_mismatch;
      ld(2, 32'h3000, 8'd0);
      sto(2, 32'h3004, 8'd0);
      chk("R5 addr mismatch status", c_st, 1);
      chk("R6 cleared after fail", armed, 0);
      sto(2, 32'h3000, 8'd0);
      chk("R6 later store fails", c_st, 1);
   endtask

   task automatic t_snoop;
      ld(0, 32'h4001, 8'd0);
      cyc(0, 0, 0, '0, '0, 1, 32'h4003, 0);
      chk("R7 snoop hit drops", armed, 0);
      sto(0, 32'h4001, 8'd0);
      chk("R7 store after snoop", c_st, 1);
      ld(0, 32'h4001, 8'd0);
      cyc(0, 0, 0, '0, '0, 1, 32'h4004, 0);
      chk("R10 snoop miss keeps", armed, 1);
      sto(0, 32'h4001, 8'd0);
      chk("R10 store ok after miss", c_wr, 1);
      ld(2, 32'h4100, 8'd0);
      cyc(1, 1, 2, 32'h4100, 8'd0, 1, 32'h4102, 0);
      chk("R7 same-cycle snoop fails", c_st, 1);
   endtask

   task automatic t_clear;
      ld(2, 32'h5000, 8'd0);
      cyc(0, 0, 0, '0, '0, 0, '0, 1);
      chk("R8 clear opens", armed, 0);
      ld(2, 32'h5000, 8'd0);
      cyc(1, 1, 2, 32'h5000, 8'd0, 0, '0, 1);
      chk("R8 clear with store", c_st, 1);
      cyc(1, 0, 2, 32'h5000, 8'd0, 0, '0, 1);
      chk("R8 clear beats load", armed, 0);
   endtask

   task automatic t_reload;
      ld(2, 32'h5000, 8'd0);
      ld(2, 32'h6000, 8'd0);
      sto(2, 32'h5000, 8'd0);
      chk("R9 old addr fails", c_st, 1);
      ld(2, 32'h5000, 8'd0);
      ld(2, 32'h6000, 8'd0);
      sto(2, 32'h6000, 8'd0);
      chk("R9 new addr ok", c_wr, 1);
   endtask

   task automatic t_rsvd;
      ld(3, 32'h7000, 8'd0);
      chk("R1 rsvd load no arm", armed, 0);
      ld(2, 32'h7000, 8'd0);
      sto(3, 32'h7000, 8'd0);
      chk("R1 rsvd store fails", c_st, 1);
   endtask

   task automatic t_offsets;
      ld(0, 32'h7001, 8'd5);
      chk("R2 byte ignores imm", c_eff, 32'h7001);
      ld(1, 32'h7002, 8'd9);
      chk("R2 half ignores imm", c_eff, 32'h7002);
      ld(2, 32'h8000, 8'd255);
      chk("R2 max offset", c_eff, 32'h83FC);
      sto(2, 32'h83FC, 8'd0);
      chk("R4 store via base only", c_wr, 1);
   endtask

   task automatic t_mid_reset;
      ld(2, 32'h9000, 8'd0);
      @(negedge clk); rst_n = 0;
      @(posedge clk); #1;
      chk("R8 mid reset opens", armed, 0);
      rst_n = 1;
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1;
      t_word_ok();
      t_unarmed();
      t_size_mismatch();
      t_addr_mismatch();
      t_snoop();
      t_clear();
      t_reload();
      t_rsvd();
      t_offsets();
      t_mid_reset();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule